// File: doc/BRIEF.md
# Ramped-Sensing Page Buffer Array

This block turns one word-line ramp into a multi-bit threshold reading for every bit line of a page at once. A single step counter walks from a programmable start code to a programmable end code. Its value goes out on a port that feeds the word-line DAC, and the same value goes to every page-buffer slot. Each ramp step runs the same sequence of phases: the code is set, the bit lines are precharged, the sense amplifiers are strobed, and then the slots update.

In read mode, each slot stores the code of the first step at which its bit line was seen to discharge. After that it stops listening for the rest of the ramp. In verify mode, each slot raises an inhibit flag when its bit line is still charged at the step whose code equals that slot's target code. The start and end codes are programmable, so the analog window can be moved, for example to follow temperature. The analog DAC, the sense amplifiers and the precharge circuits sit outside the block and talk to it through ports.

Top module: `rsp_array`

## Requirements
- R1: After reset every captured code is all ones, every inhibit flag is 0, `done_o` and `busy_o` are 0 and `wl_code_o` is 0.
- R2: An accepted start sets `wl_code_o` to the start code in the next cycle. The code then rises by exactly one per step. Every step lasts SET_CYC + PRE_CYC + 2 cycles: SET_CYC cycles of setup, PRE_CYC cycles with `precharge_o` high, one cycle with `strobe_o` high, and one update cycle.
- R3: In read mode (`verify_i` = 0 at start), each slot stores the code of the first step whose strobe cycle saw its `sense_i` bit at 1 (1 = discharged, the cell conducts). Sense values at later steps do not change the stored code.
- R4: In read mode, a slot whose bit line never discharges during the ramp keeps the all-ones code.
- R5: In verify mode (`verify_i` = 1 at start), a slot's inhibit flag is set when its sense bit is 0 at the step whose code equals its target code. A sense bit of 1 at that step sets nothing. Once set, the flag stays set until the next ramp starts. Captured codes stay all ones in verify mode, and inhibit flags stay 0 in read mode.
- R6: The start code, end code and mode are taken at the accepting edge. The ramp ends after the step whose code equals the end code. If the start code is above the end code, the ramp ends after the all-ones step instead.
- R7: `done_o` is high for exactly one cycle, the cycle after the update cycle of the last step. `busy_o` is high from the cycle after the start is accepted up to that cycle.
- R8: A `start_i` pulse that arrives while a ramp is running is ignored. The running ramp keeps its mode, codes and length.
- R9: Accepting a start clears every slot to the all-ones code and a 0 inhibit flag, and re-enables capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a ramp (taken only when idle) |
| verify_i | input | 1 | 0 = read ramp, 1 = program-verify ramp |
| start_code_i | input | CODE_W | First ramp code |
| end_code_i | input | CODE_W | Last ramp code |
| sense_i | input | NUM_BL | Per-bit-line sense output, 1 = discharged |
| target_i | input | NUM_BL*CODE_W | Per-bit-line verify target, slot b at bits [b*CODE_W +: CODE_W] |
| wl_code_o | output | CODE_W | Ramp code to the word-line DAC |
| precharge_o | output | 1 | Bit-line precharge phase |
| strobe_o | output | 1 | Sense strobe phase |
| vt_code_o | output | NUM_BL*CODE_W | Captured threshold codes, slot b at bits [b*CODE_W +: CODE_W] |
| inhibit_o | output | NUM_BL | Per-bit-line program inhibit flags |
| busy_o | output | 1 | Ramp in progress |
| done_o | output | 1 | One-cycle end-of-ramp pulse |

## Verification
Some properties are checked on every cycle by assertions. The ramp code never drops below the latched start code and rises by one between steps. `done_o` never lasts two cycles. A ramp cannot stop early. A captured code cannot move once its slot is disabled. An inhibit flag never falls during a ramp and never appears in read mode. Other behaviour can only be shown by the bench's scenarios, which drive a threshold model of the cells. These are the actual code each slot captures under various thresholds and windows, the inhibit pattern against targets inside and outside the window, the wrap to all ones when start exceeds end, the clearing between ramps, and the exact ramp length with a stray start pulse mid-ramp.

// File: rtl/rsp_pkg.sv
// Shared types for the ramped-sensing page buffer array.
package rsp_pkg;

    // Phases of one ramp step, in the order they run.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SET    = 3'd1,
        PH_PRE    = 3'd2,
        PH_STROBE = 3'd3,
        PH_LATCH  = 3'd4
    } rsp_phase_e;

endpackage

// File: rtl/rsp_sequencer.sv
// Ramp sequencer: owns the shared step counter and the per-step phase timing.
// Assumes SET_CYC >= 1 and PRE_CYC >= 1. Start/end codes and mode are
// captured when a start is accepted in idle; starts while busy are dropped.
module rsp_sequencer
    import rsp_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int SET_CYC = 1,
    parameter int PRE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              verify_i,
    input  logic [CODE_W-1:0] start_code_i,
    input  logic [CODE_W-1:0] end_code_i,
    output logic [CODE_W-1:0] code_o,
    output rsp_phase_e        phase_o,
    output logic              verify_o,
    output logic              clr_o,
    output logic              done_o
);
    localparam int MAX_CYC = (SET_CYC > PRE_CYC) ? SET_CYC : PRE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SET_CYC - 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CYC - 1);

    rsp_phase_e        phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] start_q;
    logic [CODE_W-1:0] end_q;
    logic              verify_q;
    logic              done_q;
    logic              last_step;

    // Final step: end code reached, or the counter is at its top value.
    assign last_step = (code_q == end_q) || (code_q == {CODE_W{1'b1}});
    // Slots clear on the same edge that accepts a start.
    assign clr_o     = (phase_q == PH_IDLE) && start_i;

    // Phase walk, step counter and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            code_q   <= '0;
            start_q  <= '0;
            end_q    <= '0;
            verify_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q  <= PH_SET;
                        cnt_q    <= '0;
                        code_q   <= start_code_i;
                        start_q  <= start_code_i;
                        end_q    <= end_code_i;
                        verify_q <= verify_i;
                    end
                end
                PH_SET: begin
                    if (cnt_q == SET_LAST) begin
                        phase_q <= PH_PRE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_PRE: begin
                    if (cnt_q == PRE_LAST) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_STROBE: phase_q <= PH_LATCH;
                PH_LATCH: begin
                    if (last_step) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        phase_q <= PH_SET;
                        code_q  <= code_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign code_o   = code_q;
    assign phase_o  = phase_q;
    assign verify_o = verify_q;
    assign done_o   = done_q;

    // R6: while running, the code never sits below the captured start code.
    assert_code_ge_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |-> (code_q >= start_q));

    // R2: a non-final update cycle advances the code by exactly one.
    assert_step_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LATCH && !last_step) |=> (code_q == $past(code_q) + 1'b1));

    // R7: done never lasts two cycles.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R8: a running ramp only leaves through the final update cycle.
    assert_no_early_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && !(phase_q == PH_LATCH && last_step))
        |=> (phase_q != PH_IDLE));
endmodule

// File: rtl/rsp_slot.sv
// One page-buffer slot: samples its sense bit on the strobe cycle and, in the
// update cycle, either captures the ramp code (read) or raises inhibit (verify).
// Assumes strobe and latch are never high together and clr overrides both.
module rsp_slot #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              strobe_i,
    input  logic              latch_i,
    input  logic              verify_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              sense_i,
    input  logic [CODE_W-1:0] target_i,
    output logic [CODE_W-1:0] vt_o,
    output logic              inhibit_o
);
    logic [CODE_W-1:0] vt_q;
    logic              en_q;
    logic              samp_q;
    logic              inh_q;

    // Sense sampling, first-discharge capture and inhibit decision.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            vt_q   <= {CODE_W{1'b1}};
            en_q   <= 1'b1;
            samp_q <= 1'b0;
            inh_q  <= 1'b0;
        end else begin
            if (strobe_i) begin
                samp_q <= sense_i;
            end
            if (latch_i) begin
                if (!verify_i && en_q && samp_q) begin
                    vt_q <= code_i;
                    en_q <= 1'b0;
                end
                if (verify_i && !samp_q && (code_i == target_i)) begin
                    inh_q <= 1'b1;
                end
            end
        end
    end

    assign vt_o      = vt_q;
    assign inhibit_o = inh_q;

    // R3: once disabled, the captured code holds until the next clear.
    assert_capture_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !clr_i) |=> $stable(vt_q));

    // R5: inhibit is sticky within a ramp.
    assert_inhibit_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_q && !clr_i) |=> inh_q);

    // R5: read ramps never raise inhibit.
    assert_no_inhibit_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !verify_i |-> !inh_q);
endmodule

// File: rtl/rsp_array.sv
// Ramped-sensing page buffer array: one sequencer shared by NUM_BL slots.
// The ramp code goes to the word-line DAC port and to every slot.
// Assumes the sense inputs are settled by the strobe cycle of each step.
module rsp_array
    import rsp_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int NUM_BL  = 8,
    parameter int SET_CYC = 1,
    parameter int PRE_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     verify_i,
    input  logic [CODE_W-1:0]        start_code_i,
    input  logic [CODE_W-1:0]        end_code_i,
    input  logic [NUM_BL-1:0]        sense_i,
    input  logic [NUM_BL*CODE_W-1:0] target_i,
    output logic [CODE_W-1:0]        wl_code_o,
    output logic                     precharge_o,
    output logic                     strobe_o,
    output logic [NUM_BL*CODE_W-1:0] vt_code_o,
    output logic [NUM_BL-1:0]        inhibit_o,
    output logic                     busy_o,
    output logic                     done_o
);
    rsp_phase_e        phase;
    logic [CODE_W-1:0] code;
    logic              verify_mode;
    logic              clr;
    logic              latch;

    rsp_sequencer #(
        .CODE_W (CODE_W),
        .SET_CYC(SET_CYC),
        .PRE_CYC(PRE_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .verify_i    (verify_i),
        .start_code_i(start_code_i),
        .end_code_i  (end_code_i),
        .code_o      (code),
        .phase_o     (phase),
        .verify_o    (verify_mode),
        .clr_o       (clr),
        .done_o      (done_o)
    );

    // Phase decode shared by the analog ports and the slots.
    assign precharge_o = (phase == PH_PRE);
    assign strobe_o    = (phase == PH_STROBE);
    assign latch       = (phase == PH_LATCH);
    assign busy_o      = (phase != PH_IDLE);
    assign wl_code_o   = code;

    for (genvar b = 0; b < NUM_BL; b++) begin : g_slot
        rsp_slot #(
            .CODE_W(CODE_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr),
            .strobe_i (strobe_o),
            .latch_i  (latch),
            .verify_i (verify_mode),
            .code_i   (code),
            .sense_i  (sense_i[b]),
            .target_i (target_i[b*CODE_W +: CODE_W]),
            .vt_o     (vt_code_o[b*CODE_W +: CODE_W]),
            .inhibit_o(inhibit_o[b])
        );
    end
endmodule

// File: tb/rsp_array_bench.sv
module rsp_array_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 4;
    localparam int NB   = 8;
    localparam int SETC = 1;
    localparam int PREC = 2;
    localparam int STEP = SETC + PREC + 2;

    typedef struct packed {
        logic           vf;
        logic [CW-1:0]  s;
        logic [CW-1:0]  e;
        logic [NB*CW-1:0] vt;
        logic [NB*CW-1:0] tg;
    } vec_t;

    // Per-vector: mode, window, cell thresholds, verify targets.
    localparam vec_t VECS [5] = '{
        '{1'b0, 4'd0,  4'd15, 32'hFEB87410, 32'h00000000},
        '{1'b0, 4'd3,  4'd10, 32'h5FBA6320, 32'h00000000},
        '{1'b1, 4'd0,  4'd15, 32'h690F4882, 32'h6C034844},
        '{1'b1, 4'd5,  4'd9,  32'hFFFFFFFF, 32'h60F7A952},
        '{1'b0, 4'd12, 4'd4,  32'hB1EC5FD0, 32'h00000000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic verify_i = 1'b0;
    logic [CW-1:0] start_code_i = '0;
    logic [CW-1:0] end_code_i = '0;
    logic [NB-1:0] sense_i;
    logic [NB*CW-1:0] target_i = '0;
    logic [CW-1:0] wl_code_o;
    logic precharge_o, strobe_o, busy_o, done_o;
    logic [NB*CW-1:0] vt_code_o;
    logic [NB-1:0] inhibit_o;
    logic [NB*CW-1:0] cell_vt = '1;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    rsp_array #(.CODE_W(CW), .NUM_BL(NB), .SET_CYC(SETC), .PRE_CYC(PREC)) u_rsp_array (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .verify_i(verify_i),
        .start_code_i(start_code_i), .end_code_i(end_code_i), .sense_i(sense_i),
        .target_i(target_i), .wl_code_o(wl_code_o), .precharge_o(precharge_o),
        .strobe_o(strobe_o), .vt_code_o(vt_code_o), .inhibit_o(inhibit_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Cell model: a cell conducts once the word-line code reaches its threshold.
    always_comb begin
        for (int b = 0; b < NB; b++) sense_i[b] = (wl_code_o >= cell_vt[b*CW +: CW]);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] stop_of(input logic [CW-1:0] s, input logic [CW-1:0] e);
        return (s <= e) ? e : {CW{1'b1}};
    endfunction

    function automatic logic [NB*CW-1:0] exp_vt(input vec_t v);
        logic [NB*CW-1:0] r = '1;
        logic [CW-1:0] stp = stop_of(v.s, v.e);
        if (v.vf) return r;
        for (int b = 0; b < NB; b++) begin
            logic [CW-1:0] c = v.vt[b*CW +: CW];
            logic [CW-1:0] m = (c > v.s) ? c : v.s;
            r[b*CW +: CW] = (m <= stp) ? m : {CW{1'b1}};
        end
        return r;
    endfunction

    function automatic logic [NB-1:0] exp_inh(input vec_t v);
        logic [NB-1:0] r = '0;
        logic [CW-1:0] stp = stop_of(v.s, v.e);
        if (!v.vf) return r;
        for (int b = 0; b < NB; b++) begin
            logic [CW-1:0] t = v.tg[b*CW +: CW];
            r[b] = (t >= v.s) && (t <= stp) && (v.vt[b*CW +: CW] > t);
        end
        return r;
    endfunction

    // Start a ramp, optionally pulse a stray start after inj cycles,
    // and return the cycles from the accepting edge to done.
    task automatic run_ramp(input vec_t v, input int inj, output int n);
        @(negedge clk);
        cell_vt = v.vt; target_i = v.tg; verify_i = v.vf;
        start_code_i = v.s; end_code_i = v.e; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start_i = (n == inj);
            if (start_i) begin
                verify_i = ~v.vf; start_code_i = 4'd0; end_code_i = 4'd15;
            end
            if (done_o || n > 2000) break;
        end
        start_i = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        vec_t v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(vt_code_o == '1 && inhibit_o == '0 && !busy_o && !done_o && wl_code_o == '0,
            "R1", "reset state", {vt_code_o, inhibit_o, busy_o, done_o}, {32'hFFFFFFFF, 8'h00, 2'b00});

        // R2: first step code and busy after acceptance
        start_code_i = 4'd6; end_code_i = 4'd6; verify_i = 1'b0; cell_vt = '1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o && wl_code_o == 4'd6, "R2", "first code", {busy_o, wl_code_o}, {1'b1, 4'd6});
        repeat (SETC) @(negedge clk);
        chk(precharge_o && !strobe_o, "R2", "precharge phase", {precharge_o, strobe_o}, 2'b10);
        repeat (PREC) @(negedge clk);
        chk(strobe_o && !precharge_o, "R2", "strobe phase", {precharge_o, strobe_o}, 2'b01);
        repeat (2) @(negedge clk);
        chk(done_o, "R7", "done after one step", done_o, 1'b1);
        @(negedge clk);
        chk(!done_o && !busy_o, "R7", "done one cycle", {done_o, busy_o}, 2'b00);

        // Table walk: R3/R4/R5/R6/R9 plus ramp length (R2)
        for (int i = 0; i < 5; i++) begin
            v = VECS[i];
            run_ramp(v, -1, n);
            chk(vt_code_o == exp_vt(v), "R3/R4/R9", $sformatf("codes vec %0d", i), vt_code_o, exp_vt(v));
            chk(inhibit_o == exp_inh(v), "R5", $sformatf("inhibit vec %0d", i), inhibit_o, exp_inh(v));
            chk(n == (int'(stop_of(v.s, v.e)) - int'(v.s) + 1) * STEP, "R2/R6",
                $sformatf("ramp length vec %0d", i), n, (int'(stop_of(v.s, v.e)) - int'(v.s) + 1) * STEP);
        end

        // R8: stray start mid-ramp is ignored
        v = '{1'b0, 4'd0, 4'd3, 32'hFEB87410, 32'h0};
        run_ramp(v, 7, n);
        chk(n == 4 * STEP, "R8", "length with stray start", n, 4 * STEP);
        chk(vt_code_o == exp_vt(v) && inhibit_o == '0, "R8", "result with stray start",
            {vt_code_o, inhibit_o}, {exp_vt(v), 8'h00});
        @(negedge clk);
        chk(!done_o && !busy_o, "R7", "done pulse ends", {done_o, busy_o}, 2'b00);

        // R9: verify ramp after read clears captured codes to all ones
        v = '{1'b1, 4'd0, 4'd15, 32'h00000000, 32'hFFFFFFFF};
        run_ramp(v, -1, n);
        chk(vt_code_o == '1 && inhibit_o == '0, "R9", "clear between ramps",
            {vt_code_o, inhibit_o}, {32'hFFFFFFFF, 8'h00});

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule